// File: doc/BRIEF.md
# Masked-Write GPIO Port Register File

This block holds the control state for one port of eight general-purpose pins. Three control registers set, per pin, whether the pin is handed to GPIO control, whether it drives, and what level it drives. A fourth, read-only register reports the pin levels after synchronisation. The pad-facing outputs carry the gated output enable and output value, and the pad inputs come back in through a two-flop synchroniser.

Each control register can be written in two ways. A plain write replaces the whole register. A masked write goes to an alias placed a fixed distance above the plain registers. Its upper byte picks the pins to change and its lower byte gives their new levels, so software can flip one pin without first reading the register. The bus is a simple synchronous one: address, write strobe, per-byte lane enables, write data, and read data that is registered one cycle after the address.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is held, all three control registers clear to 0 and read data clears to 0. Pad output enable and pad output value are then 0.
- R2: A plain write with lane 0 enabled replaces the whole register with write data bits 7:0. The plain offsets are 0x00 for configuration, 0x10 for output enable and 0x20 for output value, each plus four times the port index.
- R3: A masked write to alias base 0x080 plus the same relative offset sets pin n to write data bit n wherever write data bit 8+n is 1. Every pin whose bit 8+n is 0 keeps its state.
- R4: A read of a masked alias returns the register value in bits 7:0 and zero in every bit above.
- R5: The input register (plain offset 0x30) shows pad levels through two synchroniser flops. A change on the pads appears on read data on the third rising edge, with the address held.
- R6: Writes to the input register offset change no control register.
- R7: Pad output enable bit n is 1 only when configuration bit n and output-enable bit n are both 1. Pad output bit n is 1 only when configuration bit n and output-value bit n are both 1.
- R8: A plain write with lane 0 disabled is ignored. A masked write changes nothing unless lanes 0 and 1 are both enabled.
- R9: Addresses that match no register read as 0, and writes to them have no effect. This covers other port indices and the masked alias of the input offset.
- R10: Read data is registered. When a write and a read hit the same address in one cycle, the value returned is the one held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_be | input | DATA_W/8 | Byte-lane enables |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered from the previous cycle's address |
| pad_in | input | PINS | Raw pad levels |
| pad_oe | output | PINS | Gated output enable to the pads |
| pad_out | output | PINS | Gated output value to the pads |

## Verification
The case hardest to reach from the ports is a masked write that lands on a register already holding a mix of ones and zeros. Only there can a pin outside the mask be seen keeping its state while the selected pins change in both directions. The vector table therefore first loads each register with an irregular pattern through plain writes. Masked writes then follow, with masks that cover set and clear bits, an empty mask, and a disabled upper lane. The gating of the pad outputs is checked only after configuration, enable and value have been left in patterns that differ from one another.

// File: rtl/gpio_port_pkg.sv
// Shared types for the GPIO port register file.
package gpio_port_pkg;

    // Register targeted by a bus address
    typedef enum logic [2:0] {
        REG_NONE = 3'd0,
        REG_CFG  = 3'd1,
        REG_OE   = 3'd2,
        REG_OUT  = 3'd3,
        REG_IN   = 3'd4
    } reg_id_e;

    // Decoded access: which register and whether through the masked alias
    typedef struct packed {
        reg_id_e id;
        logic    masked;
    } reg_sel_t;

    localparam int NUM_CTRL = 3;

    // Map control-register index to its identifier
    function automatic reg_id_e ctrl_id(input int idx);
        case (idx)
            0:       return REG_CFG;
            1:       return REG_OE;
            default: return REG_OUT;
        endcase
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
// Address decoder: turns a byte address into a register selection.
// Assumes plain registers at 0x00/0x10/0x20/0x30 plus PORT_IDX*4, and
// masked aliases MASK_BASE above the three control registers only.
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PORT_IDX  = 0,
    parameter int MASK_BASE = 'h080
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam logic [ADDR_W-1:0] PORT_OFS = ADDR_W'(PORT_IDX * 4);
    localparam logic [ADDR_W-1:0] A_CFG    = PORT_OFS + ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] A_OE     = PORT_OFS + ADDR_W'('h10);
    localparam logic [ADDR_W-1:0] A_OUT    = PORT_OFS + ADDR_W'('h20);
    localparam logic [ADDR_W-1:0] A_IN     = PORT_OFS + ADDR_W'('h30);
    localparam logic [ADDR_W-1:0] M_OFS    = ADDR_W'(MASK_BASE);

    // Compare the address against every mapped location
    always_comb begin
        sel = '{id: REG_NONE, masked: 1'b0};
        if      (addr == A_CFG)         sel = '{id: REG_CFG, masked: 1'b0};
        else if (addr == A_OE)          sel = '{id: REG_OE,  masked: 1'b0};
        else if (addr == A_OUT)         sel = '{id: REG_OUT, masked: 1'b0};
        else if (addr == A_IN)          sel = '{id: REG_IN,  masked: 1'b0};
        else if (addr == A_CFG + M_OFS) sel = '{id: REG_CFG, masked: 1'b1};
        else if (addr == A_OE + M_OFS)  sel = '{id: REG_OE,  masked: 1'b1};
        else if (addr == A_OUT + M_OFS) sel = '{id: REG_OUT, masked: 1'b1};
    end
endmodule

// File: rtl/gpio_ctrl_reg.sv
// One per-pin control register supporting whole-word and masked updates.
// Assumes the two write strobes are never both high.
module gpio_ctrl_reg #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            plain_wr,
    input  logic            mask_wr,
    input  logic [PINS-1:0] wr_val,
    input  logic [PINS-1:0] wr_mask,
    output logic [PINS-1:0] q
);
    // Hold, replace, or merge the selected pins
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (plain_wr) q <= wr_val;
        else if (mask_wr)  q <= (q & ~wr_mask) | (wr_val & wr_mask);
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Multi-flop synchroniser for the asynchronous pad inputs.
// Assumes STAGES >= 2; each pin is synchronised independently.
module gpio_in_sync #(
    parameter int PINS   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] d,
    output logic [PINS-1:0] q
);
    logic [PINS-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the pad level one flop further along the chain
        always_ff @(posedge clk) begin
            if (!rst_n)      stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d;
            else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
// Register file for one GPIO port: configuration, output enable and
// output value with plain and masked write aliases, plus a synchronised
// input register. Assumes PINS <= 8 so that values sit in byte lane 0
// and masks in byte lane 1, and DATA_W >= 16.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS      = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int PORT_IDX  = 0,
    parameter int MASK_BASE = 'h080,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out
);
    localparam int LANES = DATA_W / 8;

    reg_sel_t        sel;
    logic [PINS-1:0] ctrl_q [NUM_CTRL];
    logic [PINS-1:0] cfg_q, oe_q, out_q, in_q;
    logic [PINS-1:0] wr_val, wr_mask;
    logic            plain_ok, mask_ok;
    logic [DATA_W-1:0] rdata_d;
    logic            unused_bus_bits;

    gpio_addr_decode #(
        .ADDR_W(ADDR_W), .PORT_IDX(PORT_IDX), .MASK_BASE(MASK_BASE)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_q)
    );

    assign wr_val   = bus_wdata[PINS-1:0];
    assign wr_mask  = bus_wdata[8+PINS-1:8];
    assign plain_ok = bus_we && bus_be[0] && !sel.masked;
    assign mask_ok  = bus_we && bus_be[0] && bus_be[1] && sel.masked;

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
        gpio_ctrl_reg #(.PINS(PINS)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .plain_wr(plain_ok && sel.id == ctrl_id(i)),
            .mask_wr (mask_ok  && sel.id == ctrl_id(i)),
            .wr_val  (wr_val),
            .wr_mask (wr_mask),
            .q       (ctrl_q[i])
        );
    end

    assign cfg_q = ctrl_q[0];
    assign oe_q  = ctrl_q[1];
    assign out_q = ctrl_q[2];

    // Pads are driven only for pins handed to GPIO control
    assign pad_oe  = cfg_q & oe_q;
    assign pad_out = cfg_q & out_q;

    // Select the read value; aliases return the register zero-extended
    always_comb begin
        rdata_d = '0;
        case (sel.id)
            REG_CFG: rdata_d[PINS-1:0] = cfg_q;
            REG_OE:  rdata_d[PINS-1:0] = oe_q;
            REG_OUT: rdata_d[PINS-1:0] = out_q;
            REG_IN:  rdata_d[PINS-1:0] = in_q;
            default: rdata_d = '0;
        endcase
    end

    // Register the read data for the one-cycle bus latency
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rdata_d;
    end

    assign unused_bus_bits = ^{bus_wdata, bus_be[LANES-1:0]};
endmodule

// File: rtl/gpio_port_regs_chk.sv
// Property checker for gpio_port_regs, attached by bind below.
module gpio_port_regs_chk #(
    parameter int PINS      = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int PORT_IDX  = 0,
    parameter int MASK_BASE = 'h080
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W/8-1:0] bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PINS-1:0]   cfg_q,
    input logic [PINS-1:0]   oe_q,
    input logic [PINS-1:0]   out_q,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_out
);
    localparam logic [ADDR_W-1:0] P = ADDR_W'(PORT_IDX * 4);
    localparam logic [ADDR_W-1:0] M = ADDR_W'(MASK_BASE);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cfg_q == '0 && oe_q == '0 && out_q == '0 && bus_rdata == '0));

    a_r7_pad_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~cfg_q) == '0) && ((pad_out & ~cfg_q) == '0));

    a_r3_unmasked_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_be[1:0] == 2'b11 && bus_addr == P + M)
        |=> ((cfg_q ^ $past(cfg_q)) & ~$past(bus_wdata[8+PINS-1:8])) == '0);

    a_r6_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == P + ADDR_W'('h30))
        |=> ($stable(cfg_q) && $stable(oe_q) && $stable(out_q)));

    a_r8_lane0_off: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_be[0])
        |=> ($stable(cfg_q) && $stable(oe_q) && $stable(out_q)));

    a_r4_alias_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == P + M || bus_addr == P + M + ADDR_W'('h10) ||
         bus_addr == P + M + ADDR_W'('h20))
        |=> bus_rdata[DATA_W-1:PINS] == '0);
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PORT_IDX(PORT_IDX), .MASK_BASE(MASK_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_q(cfg_q), .oe_q(oe_q), .out_q(out_q),
    .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe, pad_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    gpio_port_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  be;
        logic [11:0] waddr;
        logic [31:0] wdata;
        logic [11:0] raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'b0001, 12'h000, 32'h0000_00A5, 12'h000, 32'h0000_00A5}, // R2 cfg
        '{1'b1, 4'b0001, 12'h010, 32'h0000_003C, 12'h010, 32'h0000_003C}, // R2 oe
        '{1'b1, 4'b0001, 12'h020, 32'h0000_00FF, 12'h020, 32'h0000_00FF}, // R2 out
        '{1'b1, 4'b0011, 12'h080, 32'h0000_0F0A, 12'h000, 32'h0000_00AA}, // R3 cfg merge
        '{1'b1, 4'b0011, 12'h090, 32'h0000_8101, 12'h090, 32'h0000_003D}, // R3,R4 oe
        '{1'b1, 4'b0011, 12'h0A0, 32'h0000_00FF, 12'h020, 32'h0000_00FF}, // R3 empty mask
        '{1'b1, 4'b0001, 12'h0A0, 32'h0000_FF00, 12'h020, 32'h0000_00FF}, // R8 lane1 off
        '{1'b1, 4'b0010, 12'h000, 32'h0000_0000, 12'h000, 32'h0000_00AA}, // R8 lane0 off
        '{1'b1, 4'b1111, 12'h030, 32'hFFFF_FFFF, 12'h000, 32'h0000_00AA}, // R6 in write
        '{1'b1, 4'b1111, 12'h0B0, 32'h0000_FFFF, 12'h0B0, 32'h0000_0000}, // R9 in alias
        '{1'b1, 4'b0001, 12'h004, 32'h0000_0000, 12'h000, 32'h0000_00AA}, // R9 other port
        '{1'b0, 4'b0000, 12'h000, 32'h0000_0000, 12'h004, 32'h0000_0000}, // R9 read other
        '{1'b1, 4'b0011, 12'h0A0, 32'h0000_F000, 12'h0A0, 32'h0000_000F}  // R3,R4 clear hi
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 pads", {24'h0, pad_oe, pad_out}, 32'h0);
        rst_n = 1'b1;
        bus_read(12'h010, rd);
        check("R1 oe reg", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) bus_write(VECS[i].waddr, VECS[i].be, VECS[i].wdata);
            bus_read(VECS[i].raddr, rd);
            check($sformatf("vector %0d (R2/R3/R4/R6/R8/R9)", i), rd, VECS[i].exp);
        end

        // R7: cfg=AA, oe=3D, out=0F
        check("R7 pad_oe", {24'h0, pad_oe}, 32'h28);
        check("R7 pad_out", {24'h0, pad_out}, 32'h0A);

        // R5: input register latency
        bus_addr = 12'h030;
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        check("R5 after 1 edge", bus_rdata, 32'h0);
        @(negedge clk);
        check("R5 after 2 edges", bus_rdata, 32'h0);
        @(negedge clk);
        check("R5 after 3 edges", bus_rdata, 32'h5A);

        // R10: write and read same address in one cycle
        bus_addr = 12'h020; bus_we = 1'b1; bus_be = 4'b0001; bus_wdata = 32'h77;
        @(negedge clk);
        check("R10 old value", bus_rdata, 32'h0F);
        bus_we = 1'b0; bus_be = '0;
        @(negedge clk);
        check("R10 new value", bus_rdata, 32'h77);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pads after reset", {24'h0, pad_oe, pad_out}, 32'h0);
        rst_n = 1'b1;
        bus_read(12'h000, rd);
        check("R1 cfg after reset", rd, 32'h0);
        bus_read(12'h020, rd);
        check("R1 out after reset", rd, 32'h0);

        finish_run();
    end
endmodule